// File: doc/BRIEF.md
# Dual-Screen Horizontal Pixel Panner

This block sits between the display-memory fetch path and the pixel serializer of a display controller. It takes 16-bit memory words and turns each one into a run of pixels, most significant pixel first. On the first word of every scan line it drops a programmable number of leading pixels. The image therefore moves left with single-pixel resolution. A separate start address, kept outside this block, moves the image in whole words. Together the two give smooth horizontal scrolling.

One 8-bit configuration byte holds two 4-bit pan amounts, one for each of two screen regions. A select input chooses which amount applies to the line being fetched. The colour depth limits how many pan bits take effect, so the drop count always stays inside one word. New configuration values go into a pending copy first. They move into the active copy only on a frame-start pulse, so a line in the middle of a frame never changes its pan.

Top module: `pixel_panner`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), pix_valid is 0, word_ready is 1, and both pending and active pan amounts are 0. Lines that follow without a new frame-start therefore drop no pixels.
- R2: In the configuration byte, bits 3:0 are the pan amount of screen 0 and bits 7:4 are the pan amount of screen 1. screen_sel = 0 picks screen 0 and screen_sel = 1 picks screen 1.
- R3: A cfg_we write changes only the pending byte. The active byte takes the pending value at each clock edge where frame_start is 1. If cfg_we and frame_start occur on the same edge, the active byte takes the value that was pending before the write.
- R4: depth_code selects bits per pixel: 0 → 1, 1 → 2, 2 → 4, 3 → 8, 4 → 16. The effective pan is the selected amount ANDed with (pixels per word − 1). That keeps 4, 3, 2, 1 or 0 low bits respectively.
- R5: When a word with word_first = 1 is accepted, its first N pixels are discarded, where N is the effective pan. Words with word_first = 0 are emitted whole.
- R6: Pixels leave each word from the most significant end. Each pixel is zero-extended to 16 bits on pix_data.
- R7: A word accepted at a clock edge shows its first kept pixel on pix_valid/pix_data right after that edge. One pixel follows per cycle with no gap. word_ready is 1 when nothing is held or the last pixel of the held word is showing, so a continuously offered stream produces gap-free output.
- R8: depth_code values 5, 6 and 7 behave as 16 bits per pixel.
- R9: The pan of a line is fixed when its first word is accepted. Changing screen_sel after that has no effect on the rest of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the pending pan byte |
| cfg_wdata | input | 8 | Pan byte: [7:4] screen 1, [3:0] screen 0 |
| frame_start | input | 1 | Copies pending pan byte to active |
| screen_sel | input | 1 | Screen whose pan applies to the next first word |
| depth_code | input | 3 | Colour depth code |
| word_valid | input | 1 | Memory word offered |
| word_data | input | 16 | Memory word |
| word_first | input | 1 | Offered word is the first of a scan line |
| word_ready | output | 1 | Word is accepted when valid and ready |
| pix_valid | output | 1 | Pixel present |
| pix_data | output | 16 | Zero-extended pixel value |

## Verification
The assertions assume that depth_code changes only while no word is held, that is, between lines after the output has drained. They also assume that word_first marks only the first word of a line. Under those conditions the drop count never exceeds the pixels of one word, and a stalled word keeps the output busy. The bench changes depth and screen only after an idle stretch longer than the widest word. It toggles screen_sel mid-line only after the first word has been accepted, and it sends configuration writes and frame-start pulses between lines.

// File: rtl/pixpan_pkg.sv
// Shared constants and helpers for the pixel panner.
// Assumes depth codes 0..4 map to 1,2,4,8,16 bits per pixel; larger codes clamp to 16.
package pixpan_pkg;
    localparam int DEPTH_W   = 3;
    localparam int MAX_LG    = 4;

    typedef enum logic [DEPTH_W-1:0] {
        DEPTH_1BPP  = 3'd0,
        DEPTH_2BPP  = 3'd1,
        DEPTH_4BPP  = 3'd2,
        DEPTH_8BPP  = 3'd3,
        DEPTH_16BPP = 3'd4
    } depth_e;

    // log2 of bits per pixel for a depth code, clamped at 16 bpp
    function automatic int unsigned depth_lg(input logic [DEPTH_W-1:0] code);
        if (code > DEPTH_16BPP)
            return MAX_LG;
        return int'(code);
    endfunction
endpackage

// File: rtl/pixpan_regs.sv
// Pending and active copies of the pan byte.
// Writes land in the pending copy; frame_start moves it into the active copy.
// Assumes frame_start is a single-cycle pulse per frame.
module pixpan_regs #(
    parameter int PAN_W   = 4,
    parameter int SCREENS = 2,
    localparam int CFG_W  = PAN_W * SCREENS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             frame_start,
    output logic [CFG_W-1:0] act_pan
);
    logic [CFG_W-1:0] pend_q;
    logic [CFG_W-1:0] act_q;

    // Hold pending writes and promote them at frame boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (cfg_we)
                pend_q <= cfg_wdata;
            if (frame_start)
                act_q <= pend_q;
        end
    end

    assign act_pan = act_q;
endmodule

// File: rtl/pixpan_mask.sv
// Picks the active screen's pan amount and masks it to the pixels in one word.
// Assumes screen_sel is below SCREENS.
module pixpan_mask
    import pixpan_pkg::*;
#(
    parameter int PAN_W   = 4,
    parameter int SCREENS = 2,
    parameter int WORD_W  = 16,
    localparam int CFG_W  = PAN_W * SCREENS,
    localparam int SEL_W  = (SCREENS > 1) ? $clog2(SCREENS) : 1,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic [CFG_W-1:0]   act_pan,
    input  logic [SEL_W-1:0]   screen_sel,
    input  logic [DEPTH_W-1:0] depth_code,
    output logic [IDX_W-1:0]   skip
);
    logic [PAN_W-1:0] pan_sel;
    logic [31:0]      keep_mask;

    // Select one screen's field and limit it to (pixels per word - 1)
    always_comb begin
        pan_sel   = act_pan[32'(screen_sel) * PAN_W +: PAN_W];
        keep_mask = (32'(WORD_W) >> depth_lg(depth_code)) - 32'd1;
        skip      = IDX_W'(32'(pan_sel) & keep_mask);
    end
endmodule

// File: rtl/pixpan_serializer.sv
// Holds one memory word and emits its pixels MSB-first, one per cycle.
// On a line's first word, emission starts at the given skip index.
// Assumes depth_code is steady while a word is held and WORD_W <= 32.
module pixpan_serializer
    import pixpan_pkg::*;
#(
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic [IDX_W-1:0]   skip,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    input  logic               word_first,
    output logic               word_ready,
    output logic               pix_valid,
    output logic [WORD_W-1:0]  pix_data
);
    logic [WORD_W-1:0] buf_q;
    logic [IDX_W-1:0]  idx_q;
    logic              full_q;
    logic              last;
    logic [31:0]       lg, bpp, ppw_m1, shift, pmask;

    // Decode geometry and pick the current pixel out of the held word
    always_comb begin
        lg       = depth_lg(depth_code);
        bpp      = 32'd1 << lg;
        ppw_m1   = (32'(WORD_W) >> lg) - 32'd1;
        last     = (32'(idx_q) >= ppw_m1);
        shift    = 32'(WORD_W) - (32'(idx_q) + 32'd1) * bpp;
        pmask    = (bpp >= 32'd32) ? '1 : ((32'd1 << bpp) - 32'd1);
        pix_data = WORD_W'((32'(buf_q) >> shift) & pmask);
    end

    assign word_ready = !full_q || last;
    assign pix_valid  = full_q;

    // Load a new word or advance through the held one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (word_valid && word_ready) begin
            buf_q  <= word_data;
            idx_q  <= word_first ? skip : '0;
            full_q <= 1'b1;
        end else if (full_q) begin
            if (last)
                full_q <= 1'b0;
            else
                idx_q <= idx_q + IDX_W'(1);
        end
    end
endmodule

// File: rtl/pixel_panner.sv
// Top of the dual-screen horizontal pixel panner.
// Connects pan registers, per-screen masking and the word serializer.
// Assumes depth_code changes only between lines and word_first marks line starts.
module pixel_panner
    import pixpan_pkg::*;
#(
    parameter int PAN_W   = 4,
    parameter int SCREENS = 2,
    parameter int WORD_W  = 16,
    localparam int CFG_W  = PAN_W * SCREENS,
    localparam int SEL_W  = (SCREENS > 1) ? $clog2(SCREENS) : 1,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               frame_start,
    input  logic [SEL_W-1:0]   screen_sel,
    input  logic [DEPTH_W-1:0] depth_code,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    input  logic               word_first,
    output logic               word_ready,
    output logic               pix_valid,
    output logic [WORD_W-1:0]  pix_data
);
    logic [CFG_W-1:0] act_pan;
    logic [IDX_W-1:0] skip;

    pixpan_regs #(.PAN_W(PAN_W), .SCREENS(SCREENS)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .frame_start (frame_start),
        .act_pan     (act_pan)
    );

    pixpan_mask #(.PAN_W(PAN_W), .SCREENS(SCREENS), .WORD_W(WORD_W)) mask_i (
        .act_pan    (act_pan),
        .screen_sel (screen_sel),
        .depth_code (depth_code),
        .skip       (skip)
    );

    pixpan_serializer #(.WORD_W(WORD_W)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_code (depth_code),
        .skip       (skip),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_first (word_first),
        .word_ready (word_ready),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data)
    );
endmodule

// File: rtl/pixel_panner_chk.sv
// Property checker for pixel_panner, attached by bind.
// Assumes depth_code is steady while a word is held.
module pixel_panner_chk
    import pixpan_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int WORD_W = 16,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic [DEPTH_W-1:0] depth_code,
    input logic               word_valid,
    input logic               word_ready,
    input logic               pix_valid,
    input logic [WORD_W-1:0]  pix_data,
    input logic [CFG_W-1:0]   act_pan,
    input logic [IDX_W-1:0]   skip
);
    // R3: active pan byte only moves on a frame-start edge
    assert_pan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_pan));

    // R4: drop count never reaches a full word
    assert_skip_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(skip) <= ((32'(WORD_W) >> depth_lg(depth_code)) - 32'd1));

    // R6: emitted pixel has no bits above its depth
    assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ((32'(pix_data) >> (32'd1 << depth_lg(depth_code))) == 32'd0));

    // R7: output only starts after a word was taken
    assert_pix_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(word_valid && word_ready));

    // R7: refusing a word means pixels are still pending
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_ready |=> pix_valid);
endmodule

bind pixel_panner pixel_panner_chk #(.CFG_W(CFG_W), .WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .depth_code  (depth_code),
    .word_valid  (word_valid),
    .word_ready  (word_ready),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .act_pan     (act_pan),
    .skip        (skip)
);

// File: tb/pixel_panner_tb_top.sv
module pixel_panner_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        frame_start = 1'b0;
    logic [0:0]  screen_sel = '0;
    logic [2:0]  depth_code = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_first = 1'b0;
    logic        word_ready;
    logic        pix_valid;
    logic [15:0] pix_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R7";

    logic [15:0] exp_q[$];
    logic [7:0]  m_pend = '0;
    logic [7:0]  m_act = '0;

    always #5 clk = ~clk;

    pixel_panner dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .frame_start(frame_start), .screen_sel(screen_sel), .depth_code(depth_code),
        .word_valid(word_valid), .word_data(word_data), .word_first(word_first),
        .word_ready(word_ready), .pix_valid(pix_valid), .pix_data(pix_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bits_of(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 16;   // R8: codes 4..7 are 16 bpp
        endcase
    endfunction

    // Model the accept at the coming edge, then compare after it
    task automatic tick();
        if (rst_n && word_valid && word_ready) begin
            int bpp = bits_of(depth_code);
            int ppw = 16 / bpp;
            int skp = 0;
            if (word_first) begin
                logic [3:0] amt = m_act[screen_sel*4 +: 4];
                skp = int'(amt) % ppw;
            end
            for (int p = skp; p < ppw; p++) begin
                logic [15:0] v = '0;
                for (int b = 0; b < bpp; b++)
                    v[b] = word_data[16 - (p + 1) * bpp + b];
                exp_q.push_back(v);
            end
        end
        if (rst_n) begin
            if (frame_start) m_act = m_pend;
            if (cfg_we) m_pend = cfg_wdata;
        end
        @(negedge clk);
        if (pix_valid) begin
            if (exp_q.size() == 0)
                check(1'b0, cur_req, 1, 0);
            else begin
                logic [15:0] e = exp_q.pop_front();
                check(pix_data == e, cur_req, int'(pix_data), int'(e));
            end
        end else
            check(exp_q.size() == 0, cur_req, 0, exp_q.size());
    endtask

    task automatic send_word(input logic [15:0] d, input bit first);
        bit took;
        word_valid = 1'b1;
        word_data  = d;
        word_first = first;
        do begin
            took = word_ready;
            tick();
        end while (!took);
    endtask

    task automatic idle(input int n);
        word_valid = 1'b0;
        word_first = 1'b0;
        for (int i = 0; i < n; i++) tick();
    endtask

    // One scan line; optional gaps and a screen flip after the first word
    task automatic line(input logic sel, input logic [2:0] dep, input int nw,
                        input bit gaps, input bit flip, input int seed);
        screen_sel = sel;
        depth_code = dep;
        for (int i = 0; i < nw; i++) begin
            send_word(16'h9D2B ^ 16'(seed * 16'h3517 + i * 16'h61C3), i == 0);
            if (i == 0 && flip) screen_sel = ~sel;
            if (gaps) idle(2);
        end
        idle(18);
    endtask

    task automatic write_cfg(input logic [7:0] v, input bit with_frame);
        cfg_we = 1'b1;
        cfg_wdata = v;
        frame_start = with_frame;
        tick();
        cfg_we = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic new_frame();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        word_valid = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.delete();
        m_pend = '0;
        m_act  = '0;
        rst_n = 1'b1;
        // R1: idle outputs right after reset
        check(pix_valid == 1'b0, "R1", int'(pix_valid), 0);
        check(word_ready == 1'b1, "R1", int'(word_ready), 1);
    endtask

    initial begin
        do_reset();
        cur_req = "R1";  line(1'b0, 3'd0, 3, 1'b0, 1'b0, 1);   // no pan after reset
        cur_req = "R6";  line(1'b1, 3'd2, 2, 1'b0, 1'b0, 2);
        cur_req = "R3";  write_cfg(8'hA5, 1'b0);
        line(1'b0, 3'd0, 2, 1'b0, 1'b0, 3);                     // pending only
        new_frame();
        cur_req = "R2";  line(1'b0, 3'd0, 3, 1'b0, 1'b0, 4);   // skip 5
        cur_req = "R5";  line(1'b1, 3'd0, 3, 1'b0, 1'b0, 5);   // skip 10
        cur_req = "R4";  line(1'b1, 3'd1, 3, 1'b0, 1'b0, 6);   // A&7 = 2
        line(1'b1, 3'd2, 3, 1'b0, 1'b0, 7);                     // A&3 = 2
        line(1'b1, 3'd3, 3, 1'b0, 1'b0, 8);                     // A&1 = 0
        line(1'b0, 3'd3, 3, 1'b0, 1'b0, 9);                     // 5&1 = 1
        line(1'b0, 3'd4, 3, 1'b0, 1'b0, 10);                    // none
        cur_req = "R8";  line(1'b0, 3'd6, 3, 1'b0, 1'b0, 11);
        cur_req = "R3";  write_cfg(8'hFF, 1'b1);                // frame sees old pending
        line(1'b1, 3'd0, 2, 1'b0, 1'b0, 12);
        new_frame();
        cur_req = "R5";  line(1'b0, 3'd0, 3, 1'b0, 1'b0, 13);  // skip 15: one pixel kept
        cur_req = "R7";  line(1'b1, 3'd1, 4, 1'b1, 1'b0, 14);  // gapped stream
        line(1'b0, 3'd3, 5, 1'b0, 1'b0, 15);
        write_cfg(8'h3C, 1'b0);
        new_frame();
        cur_req = "R9";  line(1'b0, 3'd2, 3, 1'b0, 1'b1, 16);  // flip after first word
        line(1'b1, 3'd0, 3, 1'b0, 1'b1, 17);
        do_reset();
        cur_req = "R1";  line(1'b1, 3'd0, 2, 1'b0, 1'b0, 18);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule